// File: doc/BRIEF.md
# Span Attribute Interpolator

This block walks one horizontal run of pixels (constant Y) inside a triangle. A setup transfer gives it a start X, a pixel count, starting values and per-pixel steps for red, green, blue, depth and the two texture coordinates U and V, plus a mode. It then streams one pixel per accepted output transfer. Each pixel carries its X coordinate, clamped 8-bit colors, full-precision depth and texture values, and a flag on the final pixel of the run.

Every attribute is a signed fixed-point number with 16 fractional bits. The texture coordinates can be produced in three ways. The first is plain linear stepping. The second is a quadratic approximation of perspective, in which the U and V steps grow by a curvature term before each use. The third is a piecewise-linear scheme, in which the block stops at the start of every 8- or 16-pixel segment. It requests an exact texture value and slope from an external divider, then fills the segment linearly.

The control is a three-state machine. `ST_IDLE` accepts setup. It goes to `ST_RUN`, or to `ST_WAIT` in anchored mode, when the count is non-zero, and stays in `ST_IDLE` when the count is zero. `ST_WAIT` raises the anchor request and goes to `ST_RUN` when an anchor arrives. `ST_RUN` offers a pixel. It returns to `ST_IDLE` after the last pixel is taken, and goes to `ST_WAIT` after the last pixel of an anchored segment. Otherwise it stays in `ST_RUN`.

Top module: `span_interp`

## Requirements
- R1: `setup_ready` is high only while no span is active. A setup offered while a span is in progress is not taken and leaves every pixel of that span unchanged.
- R2: A setup with `setup_count` of zero produces no pixel and no anchor request, and `setup_ready` is high again on the next cycle.
- R3: The attribute lanes of `setup_start` and `setup_delta` are W bits each, with lane 0 = R, lane 1 = G, lane 2 = B, lane 3 = Z, lane 4 = U and lane 5 = V. In linear mode (`setup_mode` 0, with code 3 treated the same), pixel k of a lane equals start + k*delta, using two's-complement wrap.
- R4: The first pixel has `pix_x` equal to `setup_x`, and each later pixel has the previous X plus one, modulo 2^XW.
- R5: A span delivers exactly `setup_count` pixels. `pix_last` is high on the final one only, and the block is idle on the cycle after that pixel is taken.
- R6: While `pix_valid` is high and `pix_ready` is low, the pixel stays offered with unchanged X and attribute values. Accumulators move only on a transfer.
- R7: In quadratic mode (`setup_mode` 1), the U and V steps have `setup_ddu`/`setup_ddv` added before each advance, and the updated step is then added to the value. R, G, B and Z stay linear.
- R8: In anchored mode (`setup_mode` 2), `anchor_req` is high, and no pixel is offered, before pixel 0 and before every pixel whose index is a multiple of N. N is 8 when `setup_seg16` is 0 and 16 when it is 1. On `anchor_valid`, U and V become the anchor values and their step becomes the anchor slopes, with no curvature.
- R9: In anchored mode, the setup start, step and curvature values of U and V have no effect on any pixel.
- R10: Each color output is bits [23:16] of its lane. It is 0 when the lane is negative and 255 when the integer part exceeds 255.
- R11: After reset, `setup_ready` is high and `pix_valid` and `anchor_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_valid | input | 1 | Setup offered |
| setup_ready | output | 1 | Block idle, setup taken |
| setup_mode | input | 2 | 0 linear, 1 quadratic, 2 anchored, 3 linear |
| setup_seg16 | input | 1 | Anchored segment length: 0 gives 8, 1 gives 16 |
| setup_x | input | XW | X of the first pixel |
| setup_count | input | CW | Number of pixels |
| setup_start | input | 6*W | Start values, lanes R,G,B,Z,U,V |
| setup_delta | input | 6*W | Per-pixel steps, same lanes |
| setup_ddu | input | W | U curvature (quadratic mode) |
| setup_ddv | input | W | V curvature (quadratic mode) |
| anchor_req | output | 1 | Exact U/V needed for next segment |
| anchor_valid | input | 1 | Anchor values present |
| anchor_u | input | W | Exact U at segment start |
| anchor_v | input | W | Exact V at segment start |
| anchor_du | input | W | U slope across the segment |
| anchor_dv | input | W | V slope across the segment |
| pix_valid | output | 1 | Pixel offered |
| pix_ready | input | 1 | Pixel taken |
| pix_x | output | XW | Pixel X |
| pix_last | output | 1 | Final pixel of the span |
| pix_r | output | 8 | Clamped red |
| pix_g | output | 8 | Clamped green |
| pix_b | output | 8 | Clamped blue |
| pix_z | output | W | Depth |
| pix_u | output | W | Texture U |
| pix_v | output | W | Texture V |

## Verification
The bench goes after a zero-length span, which a faulty block would turn into a wrapped-around run of thousands of pixels, and single-pixel spans, where the last flag must coincide with the first pixel. Anchored spans whose length is not a multiple of the segment size check that no extra request is raised after the final pixel, and that a request is not skipped at a segment boundary. Colors are walked across 0 and 255 to catch wrap instead of clamping. Random back-pressure and late anchors expose an accumulator that advances on stalls. Junk setup driven mid-span shows whether a busy block wrongly reloads.

// File: rtl/span_pkg.sv
package span_pkg;

    typedef enum logic [1:0] {
        MODE_LIN     = 2'd0,
        MODE_QUAD    = 2'd1,
        MODE_ANCH    = 2'd2,
        MODE_LIN_ALT = 2'd3
    } span_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } span_state_e;

    localparam int LANES  = 6;
    localparam int LANE_R = 0;
    localparam int LANE_G = 1;
    localparam int LANE_B = 2;
    localparam int LANE_Z = 3;
    localparam int LANE_U = 4;
    localparam int LANE_V = 5;

endpackage

// File: rtl/span_ctrl.sv
module span_ctrl
    import span_pkg::*;
#(
    parameter int XW = 12,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          setup_valid,
    input  logic [1:0]    setup_mode,
    input  logic          setup_seg16,
    input  logic [XW-1:0] setup_x,
    input  logic [CW-1:0] setup_count,
    input  logic          anchor_valid,
    input  logic          pix_ready,
    output logic          setup_ready,
    output logic          anchor_req,
    output logic          pix_valid,
    output logic          pix_last,
    output logic [XW-1:0] pix_x,
    output logic          ld_setup,
    output logic          ld_anchor,
    output logic          step
);

    localparam int SEGW = 4;
    localparam logic [SEGW-1:0] SEG8_LAST  = SEGW'(7);
    localparam logic [SEGW-1:0] SEG16_LAST = SEGW'(15);

    span_state_e     state, nxt;
    logic [XW-1:0]   x_q;
    logic [CW-1:0]   remain_q;
    logic [SEGW-1:0] seg_left_q;
    logic            anch_q;
    logic            seg16_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt         = state;
        setup_ready = 1'b0;
        anchor_req  = 1'b0;
        pix_valid   = 1'b0;
        pix_last    = 1'b0;
        ld_setup    = 1'b0;
        ld_anchor   = 1'b0;
        step        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                setup_ready = 1'b1;
                ld_setup    = setup_valid;
                if (setup_valid && setup_count != '0)
                    nxt = (setup_mode == MODE_ANCH) ? ST_WAIT : ST_RUN;
            end
            ST_WAIT: begin
                anchor_req = 1'b1;
                ld_anchor  = anchor_valid;
                if (anchor_valid) nxt = ST_RUN;
            end
            ST_RUN: begin
                pix_valid = 1'b1;
                pix_last  = (remain_q == CW'(1));
                step      = pix_ready;
                if (pix_ready) begin
                    if (remain_q == CW'(1))                nxt = ST_IDLE;
                    else if (anch_q && seg_left_q == '0)   nxt = ST_WAIT;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q        <= '0;
            remain_q   <= '0;
            seg_left_q <= '0;
            anch_q     <= 1'b0;
            seg16_q    <= 1'b0;
        end else if (ld_setup) begin
            x_q      <= setup_x;
            remain_q <= setup_count;
            anch_q   <= (setup_mode == MODE_ANCH);
            seg16_q  <= setup_seg16;
        end else begin
            if (ld_anchor) seg_left_q <= seg16_q ? SEG16_LAST : SEG8_LAST;
            if (step) begin
                x_q        <= x_q + XW'(1);
                remain_q   <= remain_q - CW'(1);
                seg_left_q <= seg_left_q - SEGW'(1);
            end
        end
    end

    assign pix_x = x_q;

endmodule

// File: rtl/span_acc.sv
module span_acc #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] load_slope,
    input  logic [W-1:0] load_curv,
    input  logic         step,
    output logic [W-1:0] val
);

    logic [W-1:0] val_q, slope_q, curv_q, slope_nx;

    assign slope_nx = slope_q + curv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q   <= '0;
            slope_q <= '0;
            curv_q  <= '0;
        end else if (load) begin
            val_q   <= load_val;
            slope_q <= load_slope;
            curv_q  <= load_curv;
        end else if (step) begin
            slope_q <= slope_nx;
            val_q   <= val_q + slope_nx;
        end
    end

    assign val = val_q;

endmodule

// File: rtl/span_clamp.sv
module span_clamp #(
    parameter int W    = 32,
    parameter int FRAC = 16
) (
    input  logic [W-1:0] val,
    output logic [7:0]   byte_out
);

    logic unused_frac;
    assign unused_frac = ^val[FRAC-1:0];

    always_comb begin
        if (val[W-1])                 byte_out = 8'h00;
        else if (|val[W-2:FRAC+8])    byte_out = 8'hFF;
        else                          byte_out = val[FRAC+7:FRAC];
    end

endmodule

// File: rtl/span_interp.sv
module span_interp
    import span_pkg::*;
#(
    parameter int W    = 32,
    parameter int FRAC = 16,
    parameter int XW   = 12,
    parameter int CW   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              setup_valid,
    output logic              setup_ready,
    input  logic [1:0]        setup_mode,
    input  logic              setup_seg16,
    input  logic [XW-1:0]     setup_x,
    input  logic [CW-1:0]     setup_count,
    input  logic [6*W-1:0]    setup_start,
    input  logic [6*W-1:0]    setup_delta,
    input  logic [W-1:0]      setup_ddu,
    input  logic [W-1:0]      setup_ddv,
    output logic              anchor_req,
    input  logic              anchor_valid,
    input  logic [W-1:0]      anchor_u,
    input  logic [W-1:0]      anchor_v,
    input  logic [W-1:0]      anchor_du,
    input  logic [W-1:0]      anchor_dv,
    output logic              pix_valid,
    input  logic              pix_ready,
    output logic [XW-1:0]     pix_x,
    output logic              pix_last,
    output logic [7:0]        pix_r,
    output logic [7:0]        pix_g,
    output logic [7:0]        pix_b,
    output logic [W-1:0]      pix_z,
    output logic [W-1:0]      pix_u,
    output logic [W-1:0]      pix_v
);

    logic ld_setup, ld_anchor, step, quad_sel;
    logic [W-1:0] lane_val [LANES];
    logic [7:0]   color    [3];

    span_ctrl #(.XW(XW), .CW(CW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .setup_valid  (setup_valid),
        .setup_mode   (setup_mode),
        .setup_seg16  (setup_seg16),
        .setup_x      (setup_x),
        .setup_count  (setup_count),
        .anchor_valid (anchor_valid),
        .pix_ready    (pix_ready),
        .setup_ready  (setup_ready),
        .anchor_req   (anchor_req),
        .pix_valid    (pix_valid),
        .pix_last     (pix_last),
        .pix_x        (pix_x),
        .ld_setup     (ld_setup),
        .ld_anchor    (ld_anchor),
        .step         (step)
    );

    assign quad_sel = (setup_mode == MODE_QUAD);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [W-1:0] l_val, l_slope, l_curv;
        if (i == LANE_U || i == LANE_V) begin : g_tex
            logic [W-1:0] a_val, a_slope, dd;
            assign a_val   = (i == LANE_U) ? anchor_u  : anchor_v;
            assign a_slope = (i == LANE_U) ? anchor_du : anchor_dv;
            assign dd      = (i == LANE_U) ? setup_ddu : setup_ddv;
            assign l_val   = ld_anchor ? a_val   : setup_start[i*W +: W];
            assign l_slope = ld_anchor ? a_slope : setup_delta[i*W +: W];
            assign l_curv  = (ld_setup && quad_sel) ? dd : '0;
        end else begin : g_lin
            assign l_val   = setup_start[i*W +: W];
            assign l_slope = setup_delta[i*W +: W];
            assign l_curv  = '0;
        end
        span_acc #(.W(W)) u_acc (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       ((i == LANE_U || i == LANE_V) ? (ld_setup | ld_anchor) : ld_setup),
            .load_val   (l_val),
            .load_slope (l_slope),
            .load_curv  (l_curv),
            .step       (step),
            .val        (lane_val[i])
        );
    end

    for (genvar c = 0; c < 3; c++) begin : g_color
        span_clamp #(.W(W), .FRAC(FRAC)) u_clamp (
            .val      (lane_val[c]),
            .byte_out (color[c])
        );
    end

    assign pix_r = color[LANE_R];
    assign pix_g = color[LANE_G];
    assign pix_b = color[LANE_B];
    assign pix_z = lane_val[LANE_Z];
    assign pix_u = lane_val[LANE_U];
    assign pix_v = lane_val[LANE_V];

endmodule

// File: rtl/span_interp_chk.sv
module span_interp_chk #(
    parameter int W  = 32,
    parameter int XW = 12,
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          setup_valid,
    input logic          setup_ready,
    input logic [CW-1:0] setup_count,
    input logic          anchor_req,
    input logic          anchor_valid,
    input logic          pix_valid,
    input logic          pix_ready,
    input logic          pix_last,
    input logic [XW-1:0] pix_x,
    input logic [W-1:0]  pix_z,
    input logic [W-1:0]  pix_u
);

    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid && setup_ready && setup_count != '0 |=> !setup_ready);

    a_r1_idle_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        setup_ready |-> !pix_valid && !anchor_req);

    a_r2_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid && setup_ready && setup_count == '0 |=> setup_ready && !pix_valid);

    a_r4_x_advance: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_ready && !pix_last |=> pix_x == $past(pix_x) + 1'b1);

    a_r5_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && pix_ready && pix_last |=> setup_ready && !pix_valid);

    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !pix_ready |=> pix_valid && $stable(pix_x) && $stable(pix_u) && $stable(pix_z));

    a_r8_wait_anchor: assert property (@(posedge clk) disable iff (!rst_n)
        anchor_req && !anchor_valid |=> anchor_req && !pix_valid);

endmodule

bind span_interp span_interp_chk #(.W(W), .XW(XW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .setup_valid  (setup_valid),
    .setup_ready  (setup_ready),
    .setup_count  (setup_count),
    .anchor_req   (anchor_req),
    .anchor_valid (anchor_valid),
    .pix_valid    (pix_valid),
    .pix_ready    (pix_ready),
    .pix_last     (pix_last),
    .pix_x        (pix_x),
    .pix_z        (pix_z),
    .pix_u        (pix_u)
);

// File: tb/span_interp_test.sv
module span_interp_test;

    localparam int W = 32;
    localparam int XW = 12;
    localparam int CW = 12;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic setup_valid = 1'b0, setup_ready;
    logic [1:0] setup_mode = '0;
    logic setup_seg16 = 1'b0;
    logic [XW-1:0] setup_x = '0;
    logic [CW-1:0] setup_count = '0;
    logic [6*W-1:0] setup_start = '0, setup_delta = '0;
    logic [W-1:0] setup_ddu = '0, setup_ddv = '0;
    logic anchor_req, anchor_valid = 1'b0;
    logic [W-1:0] anchor_u = '0, anchor_v = '0, anchor_du = '0, anchor_dv = '0;
    logic pix_valid, pix_ready = 1'b0, pix_last;
    logic [XW-1:0] pix_x;
    logic [7:0] pix_r, pix_g, pix_b;
    logic [W-1:0] pix_z, pix_u, pix_v;

    int checks = 0;
    int errors = 0;

    logic [W-1:0] m_val [6];
    logic [W-1:0] m_slp [6];
    logic [W-1:0] m_crv [6];

    always #(CLK_PERIOD/2) clk = ~clk;

    span_interp uut (
        .clk(clk), .rst_n(rst_n),
        .setup_valid(setup_valid), .setup_ready(setup_ready),
        .setup_mode(setup_mode), .setup_seg16(setup_seg16),
        .setup_x(setup_x), .setup_count(setup_count),
        .setup_start(setup_start), .setup_delta(setup_delta),
        .setup_ddu(setup_ddu), .setup_ddv(setup_ddv),
        .anchor_req(anchor_req), .anchor_valid(anchor_valid),
        .anchor_u(anchor_u), .anchor_v(anchor_v),
        .anchor_du(anchor_du), .anchor_dv(anchor_dv),
        .pix_valid(pix_valid), .pix_ready(pix_ready),
        .pix_x(pix_x), .pix_last(pix_last),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .pix_z(pix_z), .pix_u(pix_u), .pix_v(pix_v)
    );

    function automatic logic [7:0] clamp8(input logic [W-1:0] v);
        if (v[W-1]) return 8'd0;
        if (v[W-2:24] != '0) return 8'd255;
        return v[23:16];
    endfunction

    function automatic logic [W-1:0] fx(input int ipart);
        return W'(ipart) << 16;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_span(input int mode, input bit seg16, input int cnt,
                            input logic [XW-1:0] x0,
                            input logic [6*W-1:0] st, input logic [6*W-1:0] dl,
                            input logic [W-1:0] ddu, input logic [W-1:0] ddv,
                            input bit junk_en);
        int idx = 0;
        int seg = 0;
        bit anch = (mode == 2);
        bit need = anch;
        bit stalled = 0;
        logic [XW-1:0] sx = '0;
        logic [W-1:0] su = '0, sz = '0;
        string uvtag;
        uvtag = (mode == 1) ? "R7" : (anch ? "R9" : "R3");
        @(negedge clk);
        setup_mode = 2'(mode); setup_seg16 = seg16; setup_x = x0;
        setup_count = CW'(cnt); setup_start = st; setup_delta = dl;
        setup_ddu = ddu; setup_ddv = ddv; setup_valid = 1'b1;
        for (int i = 0; i < 6; i++) begin
            m_val[i] = st[i*W +: W];
            m_slp[i] = dl[i*W +: W];
            m_crv[i] = '0;
        end
        if (mode == 1) begin m_crv[4] = ddu; m_crv[5] = ddv; end
        @(negedge clk);
        setup_valid = 1'b0;
        forever begin
            bit active = (idx < cnt);
            bit exp_req = anch && need && active;
            bit rdy;
            anchor_valid = 1'b0;
            if (cnt == 0)
                chk(setup_ready && !pix_valid && !anchor_req, "R2", "zero span idle",
                    {setup_ready, pix_valid, anchor_req}, 3'b100);
            chk(setup_ready == !active, "R1", "setup_ready", setup_ready, !active);
            chk(anchor_req == exp_req, "R8", "anchor_req", anchor_req, exp_req);
            chk(pix_valid == (active && !exp_req), "R5", "pix_valid", pix_valid, active && !exp_req);
            if (stalled)
                chk(pix_valid && pix_x == sx && pix_u == su && pix_z == sz, "R6", "held pixel",
                    {pix_x, pix_u}, {sx, su});
            if (!active) break;
            if (pix_valid) begin
                chk(pix_x == XW'(x0 + XW'(idx)), "R4", "pix_x", pix_x, XW'(x0 + XW'(idx)));
                chk(pix_last == (idx == cnt - 1), "R5", "pix_last", pix_last, idx == cnt - 1);
                chk(pix_r == clamp8(m_val[0]), "R10", "red", pix_r, clamp8(m_val[0]));
                chk(pix_g == clamp8(m_val[1]), "R10", "green", pix_g, clamp8(m_val[1]));
                chk(pix_b == clamp8(m_val[2]), "R10", "blue", pix_b, clamp8(m_val[2]));
                chk(pix_z == m_val[3], "R3", "depth", pix_z, m_val[3]);
                chk(pix_u == m_val[4], uvtag, "tex u", pix_u, m_val[4]);
                chk(pix_v == m_val[5], uvtag, "tex v", pix_v, m_val[5]);
            end
            rdy = ($urandom % 4) != 0;
            pix_ready = rdy;
            stalled = pix_valid && !rdy;
            sx = pix_x; su = pix_u; sz = pix_z;
            if (exp_req && ($urandom % 2) == 1) begin
                anchor_valid = 1'b1;
                anchor_u = $urandom; anchor_v = $urandom;
                anchor_du = $urandom; anchor_dv = $urandom;
                m_val[4] = anchor_u; m_val[5] = anchor_v;
                m_slp[4] = anchor_du; m_slp[5] = anchor_dv;
                m_crv[4] = '0; m_crv[5] = '0;
                need = 0;
                seg = seg16 ? 16 : 8;
            end
            if (pix_valid && rdy) begin
                for (int i = 0; i < 6; i++) begin
                    m_slp[i] = m_slp[i] + m_crv[i];
                    m_val[i] = m_val[i] + m_slp[i];
                end
                idx++;
                seg--;
                if (anch && seg == 0) need = 1;
            end
            if (junk_en && idx < cnt && ($urandom % 3) == 0) begin
                setup_valid = 1'b1;
                setup_mode = 2'($urandom); setup_count = CW'($urandom);
                setup_x = XW'($urandom);
                setup_start = {6{$urandom}}; setup_delta = {6{$urandom}};
            end else begin
                setup_valid = 1'b0;
            end
            @(negedge clk);
        end
        setup_valid = 1'b0;
        pix_ready = 1'b0;
    endtask

    function automatic logic [6*W-1:0] lanes(input logic [W-1:0] r, input logic [W-1:0] g,
                                              input logic [W-1:0] b, input logic [W-1:0] z,
                                              input logic [W-1:0] u, input logic [W-1:0] v);
        return {v, u, z, b, g, r};
    endfunction

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(setup_ready && !pix_valid && !anchor_req, "R11", "reset outputs",
            {setup_ready, pix_valid, anchor_req}, 3'b100);

        // R2 zero-length span
        run_span(0, 0, 0, 12'd5, lanes(fx(1), fx(2), fx(3), 1, 2, 3),
                 lanes(1, 1, 1, 1, 1, 1), 0, 0, 0);
        // R5 single pixel, alternate linear code
        run_span(3, 0, 1, 12'd4095, lanes(fx(10), fx(20), fx(30), 7, 8, 9),
                 lanes(fx(1), fx(1), fx(1), 1, 1, 1), 5, 5, 0);
        // R10 clamp across 255 and below 0
        run_span(0, 0, 8, 12'd100,
                 lanes(fx(250), fx(3), 32'h00FF_8000, 0, 0, 0),
                 lanes(fx(2), -fx(1), 32'h0000_4000, 32'h10, 32'h20, 32'h30), 0, 0, 1);
        // R7 quadratic
        run_span(1, 0, 12, 12'd40, lanes(fx(5), fx(6), fx(7), 32'h100, 32'h1000, 32'h2000),
                 lanes(fx(1), fx(1), fx(1), 32'h10, 32'h300, -32'sh100), 32'h40, -32'sh20, 1);
        // R8 anchored, 8-pixel segments, partial final segment
        run_span(2, 0, 20, 12'd7, lanes(fx(1), fx(2), fx(3), 4, 32'hDEAD_BEEF, 32'hCAFE_F00D),
                 lanes(fx(1), fx(1), fx(1), 1, 32'h1234, 32'h5678), 32'h99, 32'h77, 1);
        // R8 anchored, 16-pixel segments
        run_span(2, 1, 33, 12'd4090, lanes(fx(9), fx(8), fx(7), 4, 32'h1111, 32'h2222),
                 lanes(fx(1), fx(1), fx(1), 1, 32'h3333, 32'h4444), 0, 0, 1);
        // R8 exact multiple of segment length
        run_span(2, 0, 16, 12'd0, lanes(0, 0, 0, 0, 0, 0), lanes(0, 0, 0, 0, 0, 0), 0, 0, 0);

        for (int n = 0; n < 30; n++) begin
            int md = $urandom % 4;
            int cn = (($urandom % 8) == 0) ? 0 : ($urandom % 41);
            logic [6*W-1:0] st, dl;
            for (int i = 0; i < 6; i++) begin
                if (i < 3) begin
                    st[i*W +: W] = W'(int'($urandom % (320 << 16)) - (20 << 16));
                    dl[i*W +: W] = W'(int'($urandom % (16 << 16)) - (8 << 16));
                end else begin
                    st[i*W +: W] = $urandom;
                    dl[i*W +: W] = $urandom;
                end
            end
            run_span(md, 1'($urandom), cn, XW'($urandom), st, dl, $urandom, $urandom, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule